// File: doc/BRIEF.md
# Atomic Compare-and-Swap Memory Sequencer

This block carries out one atomic compare-and-exchange on a memory word. A request supplies an address, an operand size, an optional register-pair (double-width) mode, a lock qualifier, the comparand (accumulator), and the replacement value. The block reads the destination with the bus lock held and compares the data with the accumulator. It then always writes the destination back under the same lock. On a match the replacement is written. On a mismatch the data just read is written back unchanged, and the accumulator is refreshed from it. The locked read/write pair is never split. The two bus cycles use the same line address and the same byte enables.

The request side follows valid/ready rules. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the block is idle, so a producer holds its request, unchanged, until it is taken. The memory side is a request/acknowledge port: `mem_req` and every qualifier stay stable until the cycle in which `mem_ack` is high. Completion is a one-cycle `res_done` pulse. All result outputs are registered and stay valid until the next completion.

The block also produces the arithmetic flags of the comparison. It rejects misaligned operands and invalid lock or pair combinations before any bus cycle. A register destination (no lock) is compared without touching memory. The default configuration is a 64-bit register width and a 128-bit memory data bus.

Top module: `cas_seq`

## Requirements
- R1: When the operand read from the destination equals the accumulator operand, `res_success` is 1, the zero flag is 1, the replacement operand is written to the destination, and `res_acc_hi`/`res_acc_lo` return the request accumulators unchanged.
- R2: On a mismatch, `res_success` is 0 and the zero flag is 0. The low n bits of `res_acc_lo` take the value read from the destination (in pair mode the low n bits of `res_acc_hi` take its upper half). All other accumulator bits keep their request values.
- R3: Every memory operation without a fault is exactly one read handshake followed by exactly one write handshake. Both use the same `mem_addr` and `mem_be`. On a mismatch the written bytes equal the bytes read, so memory is unchanged.
- R4: In a locked operation, `mem_lock` is high on every cycle of the read and the write. The write request is presented in the cycle right after the read acknowledge, and the lock is never dropped between the two.
- R5: `req_size` codes 0, 1, 2 and 3 select 8, 16, 32 and 64 bits. `mem_addr` is `req_addr` with its low 4 bits cleared. `mem_be` bit i is set for byte lanes `req_addr[3:0]` up to `req_addr[3:0]`+bytes-1. Operand byte 0 sits in lane `req_addr[3:0]`.
- R6: With `req_pair`=1, size code 2 forms a 64-bit operand and size code 3 forms a 128-bit operand. The high register (`_hi`) supplies the upper half and the low register (`_lo`) the lower half, for both the comparand and the replacement.
- R7: If `req_addr[3:0]` is not a multiple of the operand byte count (so a 128-bit pair operation needs a 16-byte aligned address), the result is `res_fault_align`=1, no memory handshake, `res_success`=0, flags 0, and unchanged accumulators.
- R8: A locked request to a register destination, a pair request with size code 0 or 1, or a pair request to a register destination gives `res_fault_ud`=1 with no memory handshake. This fault takes priority over the alignment fault.
- R9: `res_flags` bit 0 is carry, bit 1 parity, bit 2 auxiliary carry, bit 3 zero, bit 4 sign, bit 5 overflow. The flags come from accumulator minus destination at n bits: carry is the unsigned borrow, parity is 1 for an even count of ones in the low 8 bits of the difference, auxiliary is the borrow out of bit 3, and overflow is signed overflow. In pair mode only the zero flag may be set.
- R10: An unlocked request with `req_reg_dst`=1 compares against `req_dst_val` with no memory handshake. On a match, `res_dst_val` is `req_dst_val` with its low n bits replaced by those of `req_new_lo`. Otherwise `res_dst_val` equals `req_dst_val`.
- R11: `req_ready` is high only when idle. `res_done` is high for exactly one cycle per request: after the write acknowledge, or after evaluation when there is no memory cycle. No memory request is present while `req_ready` is high.
- R12: An unlocked memory request still performs the read and the write, with `mem_lock` low on both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request taken this edge if valid |
| req_addr | input | ADDR_W | Destination byte address |
| req_size | input | 2 | Operand size code (0:8, 1:16, 2:32, 3:64 bits) |
| req_pair | input | 1 | Register-pair double-width mode |
| req_lock | input | 1 | Locked (atomic) operation requested |
| req_reg_dst | input | 1 | Destination is a register, not memory |
| req_acc_hi | input | REG_W | Accumulator, high register of the pair |
| req_acc_lo | input | REG_W | Accumulator, low register |
| req_new_hi | input | REG_W | Replacement, high register of the pair |
| req_new_lo | input | REG_W | Replacement, low register |
| req_dst_val | input | REG_W | Register destination contents |
| res_done | output | 1 | One-cycle completion pulse |
| res_success | output | 1 | Comparison matched |
| res_acc_hi | output | REG_W | Updated accumulator, high register |
| res_acc_lo | output | REG_W | Updated accumulator, low register |
| res_dst_val | output | REG_W | Updated register destination |
| res_flags | output | 6 | Comparison flags (see R9) |
| res_fault_align | output | 1 | Alignment fault |
| res_fault_ud | output | 1 | Invalid-operation fault |
| mem_req | output | 1 | Memory cycle request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_lock | output | 1 | Bus lock |
| mem_addr | output | ADDR_W | Line-aligned address |
| mem_be | output | 2*REG_W/8 | Byte enables |
| mem_wdata | output | 2*REG_W | Write data |
| mem_ack | input | 1 | Memory cycle completes |
| mem_rdata | input | 2*REG_W | Read data, valid with mem_ack |

## Verification
The bound checker watches the bus protocol on every cycle. It checks that a read acknowledge is followed at once by a write with the same lock, line address and byte enables, and that the lock holds until acknowledged. It checks that faulting operations complete with no handshake and good ones with zero or two, that the zero flag follows the success bit, and that completion is a single pulse. The values themselves can only be shown by the bench's sweep over sizes, pair mode, every lane offset, lock settings and match/mismatch: the written memory bytes, the refreshed accumulators, the flag values and the register-destination result. The bench compares all of these against arithmetic it computes itself.

// File: rtl/cas_pkg.sv
package cas_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHK,
    ST_RD,
    ST_WR,
    ST_EVL,
    ST_FIN
  } cas_state_e;

  // Bit 0 is carry, bit 5 is overflow.
  typedef struct packed {
    logic ovf;
    logic sgn;
    logic zero;
    logic aux;
    logic par;
    logic carry;
  } cas_flags_t;

  localparam int FLAG_W = 6;
endpackage

// File: rtl/cas_lane_map.sv
module cas_lane_map #(
  parameter int REG_W = 64
) (
  input  logic [1:0]                      size,
  input  logic                            pair,
  input  logic [$clog2(2*REG_W/8)-1:0]    ofs,
  input  logic [2*REG_W-1:0]              wr_op,
  input  logic [2*REG_W-1:0]              rdata,
  output logic [2*REG_W/8-1:0]            be,
  output logic [2*REG_W-1:0]              wdata,
  output logic [2*REG_W-1:0]              rd_op,
  output logic                            misalign
);
  localparam int BUS_W = 2 * REG_W;
  localparam int BUS_B = BUS_W / 8;
  localparam int OFS_W = $clog2(BUS_B);
  localparam int CNT_W = OFS_W + 1;

  logic [CNT_W-1:0] nbytes;
  logic [CNT_W-1:0] ofs_x;
  logic [BUS_W-1:0] opmask;

  assign ofs_x    = {1'b0, ofs};
  assign nbytes   = CNT_W'(1) << ({1'b0, size} + {2'b00, pair});
  assign misalign = (ofs_x & (nbytes - CNT_W'(1))) != '0;

  for (genvar i = 0; i < BUS_B; i++) begin : g_lane
    assign be[i] = (ofs_x <= CNT_W'(i)) && (CNT_W'(i) < ofs_x + nbytes);
    assign opmask[8*i +: 8] = (CNT_W'(i) < nbytes) ? 8'hFF : 8'h00;
  end

  assign wdata = (wr_op & opmask) << {ofs, 3'b000};
  assign rd_op = (rdata >> {ofs, 3'b000}) & opmask;
endmodule

// File: rtl/cas_cmp.sv
module cas_cmp
  import cas_pkg::*;
#(
  parameter int REG_W = 64
) (
  input  logic [1:0]         size,
  input  logic               pair,
  input  logic [2*REG_W-1:0] acc_op,
  input  logic [2*REG_W-1:0] dst_op,
  output logic               equal,
  output cas_flags_t         flags
);
  localparam int NSZ = $clog2(REG_W / 8) + 1;

  cas_flags_t fl [NSZ];

  for (genvar k = 0; k < NSZ; k++) begin : g_width
    localparam int W = 8 << k;
    logic [W:0] diff;
    assign diff = {1'b0, acc_op[W-1:0]} - {1'b0, dst_op[W-1:0]};
    assign fl[k] = '{
      ovf:   (acc_op[W-1] ^ dst_op[W-1]) & (diff[W-1] ^ acc_op[W-1]),
      sgn:   diff[W-1],
      zero:  diff[W-1:0] == '0,
      aux:   acc_op[4] ^ dst_op[4] ^ diff[4],
      par:   ~^diff[7:0],
      carry: diff[W]
    };
  end

  assign equal = acc_op == dst_op;

  always_comb begin
    if (pair) begin
      flags      = '0;
      flags.zero = equal;
    end else begin
      flags = fl[size];
    end
  end
endmodule

// File: rtl/cas_seq.sv
module cas_seq
  import cas_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int REG_W  = 64
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [1:0]            req_size,
  input  logic                  req_pair,
  input  logic                  req_lock,
  input  logic                  req_reg_dst,
  input  logic [REG_W-1:0]      req_acc_hi,
  input  logic [REG_W-1:0]      req_acc_lo,
  input  logic [REG_W-1:0]      req_new_hi,
  input  logic [REG_W-1:0]      req_new_lo,
  input  logic [REG_W-1:0]      req_dst_val,
  output logic                  res_done,
  output logic                  res_success,
  output logic [REG_W-1:0]      res_acc_hi,
  output logic [REG_W-1:0]      res_acc_lo,
  output logic [REG_W-1:0]      res_dst_val,
  output logic [5:0]            res_flags,
  output logic                  res_fault_align,
  output logic                  res_fault_ud,
  output logic                  mem_req,
  output logic                  mem_we,
  output logic                  mem_lock,
  output logic [ADDR_W-1:0]     mem_addr,
  output logic [2*REG_W/8-1:0]  mem_be,
  output logic [2*REG_W-1:0]    mem_wdata,
  input  logic                  mem_ack,
  input  logic [2*REG_W-1:0]    mem_rdata
);
  localparam int BUS_W = 2 * REG_W;
  localparam int BUS_B = BUS_W / 8;
  localparam int OFS_W = $clog2(BUS_B);
  localparam int SH_W  = $clog2(BUS_W) + 1;
  localparam int HALF  = REG_W / 2;

  cas_state_e st, st_nx;

  logic [ADDR_W-1:0] addr_q;
  logic [1:0]        size_q;
  logic              pair_q, lock_q, regdst_q;
  logic [REG_W-1:0]  acc_hi_q, acc_lo_q, new_hi_q, new_lo_q, dst_q;
  logic              fault_al_q, fault_ud_q;
  logic [BUS_W-1:0]  rd_q;

  logic [SH_W-1:0]   nbits;
  logic [REG_W-1:0]  nmask;
  logic [BUS_W-1:0]  acc_op, new_op, wr_op, wdata_c, rd_ext;
  logic [REG_W-1:0]  rd_hi;
  logic              misalign, eq, ud_c, al_c, load_res, fault_any;
  cas_flags_t        flags_c;

  // Operand width and mask at the selected size.
  assign nbits = SH_W'(8) << size_q;
  assign nmask = ~({REG_W{1'b1}} << nbits);

  function automatic logic [BUS_W-1:0] pack_op(
    input logic pr, input logic s0,
    input logic [REG_W-1:0] hi, input logic [REG_W-1:0] lo,
    input logic [REG_W-1:0] m);
    if (!pr)     return {{REG_W{1'b0}}, lo & m};
    else if (s0) return {hi, lo};
    else         return {{REG_W{1'b0}}, hi[HALF-1:0], lo[HALF-1:0]};
  endfunction

  assign acc_op = pack_op(pair_q, size_q[0], acc_hi_q, acc_lo_q, nmask);
  assign new_op = pack_op(pair_q, size_q[0], new_hi_q, new_lo_q, nmask);
  assign wr_op  = eq ? new_op : rd_q;
  assign rd_hi  = size_q[0] ? rd_q[BUS_W-1:REG_W]
                            : {{HALF{1'b0}}, rd_q[REG_W-1:HALF]};

  cas_lane_map #(.REG_W(REG_W)) u_lane (
    .size     (size_q),
    .pair     (pair_q),
    .ofs      (addr_q[OFS_W-1:0]),
    .wr_op    (wr_op),
    .rdata    (mem_rdata),
    .be       (mem_be),
    .wdata    (wdata_c),
    .rd_op    (rd_ext),
    .misalign (misalign)
  );

  cas_cmp #(.REG_W(REG_W)) u_cmp (
    .size   (size_q),
    .pair   (pair_q),
    .acc_op (acc_op),
    .dst_op (rd_q),
    .equal  (eq),
    .flags  (flags_c)
  );

  // Fault decode; invalid-operation outranks alignment.
  assign ud_c = (regdst_q & lock_q) | (pair_q & ~size_q[1]) | (pair_q & regdst_q);
  assign al_c = ~ud_c & ~regdst_q & misalign;

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_IDLE: if (req_valid) st_nx = ST_CHK;
      ST_CHK:  st_nx = (ud_c | al_c | regdst_q) ? ST_EVL : ST_RD;
      ST_RD:   if (mem_ack) st_nx = ST_WR;
      ST_WR:   if (mem_ack) st_nx = ST_FIN;
      ST_EVL:  st_nx = ST_FIN;
      ST_FIN:  st_nx = ST_IDLE;
      default: st_nx = ST_IDLE;
    endcase
  end

  assign req_ready = st == ST_IDLE;
  assign mem_req   = (st == ST_RD) || (st == ST_WR);
  assign mem_we    = st == ST_WR;
  assign mem_lock  = lock_q & mem_req;
  assign mem_addr  = {addr_q[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
  assign mem_wdata = (st == ST_WR) ? wdata_c : '0;
  assign res_done  = st == ST_FIN;

  assign load_res  = ((st == ST_WR) && mem_ack) || (st == ST_EVL);
  assign fault_any = fault_al_q | fault_ud_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st              <= ST_IDLE;
      addr_q          <= '0;
      size_q          <= '0;
      pair_q          <= 1'b0;
      lock_q          <= 1'b0;
      regdst_q        <= 1'b0;
      acc_hi_q        <= '0;
      acc_lo_q        <= '0;
      new_hi_q        <= '0;
      new_lo_q        <= '0;
      dst_q           <= '0;
      fault_al_q      <= 1'b0;
      fault_ud_q      <= 1'b0;
      rd_q            <= '0;
      res_success     <= 1'b0;
      res_acc_hi      <= '0;
      res_acc_lo      <= '0;
      res_dst_val     <= '0;
      res_flags       <= '0;
      res_fault_align <= 1'b0;
      res_fault_ud    <= 1'b0;
    end else begin
      st <= st_nx;
      if (st == ST_IDLE && req_valid) begin
        addr_q   <= req_addr;
        size_q   <= req_size;
        pair_q   <= req_pair;
        lock_q   <= req_lock;
        regdst_q <= req_reg_dst;
        acc_hi_q <= req_acc_hi;
        acc_lo_q <= req_acc_lo;
        new_hi_q <= req_new_hi;
        new_lo_q <= req_new_lo;
        dst_q    <= req_dst_val;
      end
      if (st == ST_CHK) begin
        fault_al_q <= al_c;
        fault_ud_q <= ud_c;
        if (regdst_q) rd_q <= {{REG_W{1'b0}}, dst_q & nmask};
      end
      if (st == ST_RD && mem_ack) rd_q <= rd_ext;
      if (load_res) begin
        res_success     <= ~fault_any & eq;
        res_flags       <= fault_any ? '0 : flags_c;
        res_fault_align <= fault_al_q;
        res_fault_ud    <= fault_ud_q;
        if (!fault_any && !eq) begin
          res_acc_lo <= (acc_lo_q & ~nmask) | (rd_q[REG_W-1:0] & nmask);
          res_acc_hi <= pair_q ? ((acc_hi_q & ~nmask) | (rd_hi & nmask)) : acc_hi_q;
        end else begin
          res_acc_lo <= acc_lo_q;
          res_acc_hi <= acc_hi_q;
        end
        res_dst_val <= (!fault_any && eq && regdst_q)
                       ? ((dst_q & ~nmask) | (new_lo_q & nmask)) : dst_q;
      end
    end
  end
endmodule

// File: rtl/cas_seq_chk.sv
module cas_seq_chk #(
  parameter int ADDR_W = 32,
  parameter int REG_W  = 64
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_valid,
  input logic                 req_ready,
  input logic                 mem_req,
  input logic                 mem_we,
  input logic                 mem_lock,
  input logic                 mem_ack,
  input logic [ADDR_W-1:0]    mem_addr,
  input logic [2*REG_W/8-1:0] mem_be,
  input logic                 res_done,
  input logic                 res_success,
  input logic [5:0]           res_flags,
  input logic                 res_fault_align,
  input logic                 res_fault_ud
);
  logic [1:0] hs_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) hs_cnt <= '0;
    else if (req_valid && req_ready) hs_cnt <= '0;
    else if (mem_req && mem_ack && hs_cnt != 2'd3) hs_cnt <= hs_cnt + 2'd1;
  end

  assert_rd_then_wr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_we && mem_ack |=> mem_req && mem_we && (mem_lock == $past(mem_lock)));

  assert_lock_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_lock && !mem_ack |=> mem_lock);

  assert_same_lanes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_we && mem_ack |=> (mem_be == $past(mem_be)) && (mem_addr == $past(mem_addr)));

  assert_fault_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    res_done && (res_fault_align || res_fault_ud) |-> hs_cnt == 2'd0);

  assert_pair_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    res_done |-> (hs_cnt == 2'd0) || (hs_cnt == 2'd2));

  assert_zero_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    res_done |-> res_flags[3] == res_success);

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    res_done |=> !res_done);

  assert_ready_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req && !res_done);
endmodule

bind cas_seq cas_seq_chk #(.ADDR_W(ADDR_W), .REG_W(REG_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .req_valid       (req_valid),
  .req_ready       (req_ready),
  .mem_req         (mem_req),
  .mem_we          (mem_we),
  .mem_lock        (mem_lock),
  .mem_ack         (mem_ack),
  .mem_addr        (mem_addr),
  .mem_be          (mem_be),
  .res_done        (res_done),
  .res_success     (res_success),
  .res_flags       (res_flags),
  .res_fault_align (res_fault_align),
  .res_fault_ud    (res_fault_ud)
);

// File: tb/sim_cas_seq.sv
`timescale 1ns/1ps
module sim_cas_seq;
  localparam int AW = 32;
  localparam int RW = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          req_valid = 1'b0, req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [1:0]    req_size = '0;
  logic          req_pair = 1'b0, req_lock = 1'b0, req_reg_dst = 1'b0;
  logic [RW-1:0] req_acc_hi = '0, req_acc_lo = '0, req_new_hi = '0, req_new_lo = '0, req_dst_val = '0;
  logic          res_done, res_success, res_fault_align, res_fault_ud;
  logic [RW-1:0] res_acc_hi, res_acc_lo, res_dst_val;
  logic [5:0]    res_flags;
  logic          mem_req, mem_we, mem_lock, mem_ack;
  logic [AW-1:0] mem_addr;
  logic [15:0]   mem_be;
  logic [127:0]  mem_wdata, mem_rdata;

  cas_seq #(.ADDR_W(AW), .REG_W(RW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_size(req_size), .req_pair(req_pair), .req_lock(req_lock),
    .req_reg_dst(req_reg_dst), .req_acc_hi(req_acc_hi), .req_acc_lo(req_acc_lo),
    .req_new_hi(req_new_hi), .req_new_lo(req_new_lo), .req_dst_val(req_dst_val),
    .res_done(res_done), .res_success(res_success), .res_acc_hi(res_acc_hi),
    .res_acc_lo(res_acc_lo), .res_dst_val(res_dst_val), .res_flags(res_flags),
    .res_fault_align(res_fault_align), .res_fault_ud(res_fault_ud),
    .mem_req(mem_req), .mem_we(mem_we), .mem_lock(mem_lock), .mem_addr(mem_addr),
    .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  // Memory model: four 16-byte lines, variable acknowledge latency.
  logic [127:0] mem [4];
  logic         pre_en = 1'b0;
  logic [1:0]   pre_idx = '0;
  logic [127:0] pre_val = '0;
  logic [1:0]   dly;
  logic [3:0]   lat_seq;

  assign mem_rdata = mem[mem_addr[5:4]];

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack <= 1'b0;
      dly     <= 2'd0;
      lat_seq <= 4'd0;
    end else begin
      if (mem_req && !mem_ack) begin
        if (dly == 2'd0) begin
          mem_ack <= 1'b1;
          lat_seq <= lat_seq + 4'd1;
          dly     <= 2'(lat_seq % 3);
        end else begin
          dly <= dly - 2'd1;
        end
      end else begin
        mem_ack <= 1'b0;
      end
    end
    if (pre_en) mem[pre_idx] <= pre_val;
    else if (mem_req && mem_we && mem_ack)
      for (int b = 0; b < 16; b++)
        if (mem_be[b]) mem[mem_addr[5:4]][8*b +: 8] <= mem_wdata[8*b +: 8];
  end

  // Handshake monitor, cleared on each accept.
  int   hs_n;
  logic first_we, last_we, lock_and, lock_or;
  logic [15:0] be_seen;
  always @(posedge clk) begin
    if (req_valid && req_ready) begin
      hs_n <= 0; lock_and <= 1'b1; lock_or <= 1'b0; first_we <= 1'b0; last_we <= 1'b0; be_seen <= '0;
    end else if (mem_req && mem_ack) begin
      hs_n <= hs_n + 1;
      if (hs_n == 0) first_we <= mem_we;
      last_we  <= mem_we;
      lock_and <= lock_and & mem_lock;
      lock_or  <= lock_or | mem_lock;
      be_seen  <= mem_be;
    end
  end

  int checks = 0;
  int errors = 0;
  int op_cnt = 0;
  logic [127:0] gold [4];

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [63:0] rnd64(input int s);
    logic [63:0] x;
    x = 64'(s + 1) * 64'h9E3779B97F4A7C15;
    x = x ^ (x >> 29);
    x = x * 64'hBF58476D1CE4E5B9;
    return x ^ (x >> 32);
  endfunction

  task automatic run_op(input int sz, input bit pr, input bit lk, input bit rdst,
                        input int ofs, input bit want_eq);
    int n, nb, line, cyc;
    logic [63:0]  m, alo, ahi, nlo, nhi, dv;
    logic [127:0] v, bm, accop, dstop, newop, wbytes, expline, exp_wr;
    logic [15:0]  exp_be;
    bit ud, al, mpath, eq;
    logic [5:0] ef;
    logic signed [129:0] as_, ds_, r_, lim;
    logic [63:0] a, d, df;
    logic [63:0] e_lo, e_hi, e_dst;
    string tg;
    op_cnt++;
    n    = 8 << sz;
    nb   = (n / 8) * (pr ? 2 : 1);
    line = op_cnt % 4;
    m    = (n == 64) ? '1 : ((64'd1 << n) - 64'd1);
    bm   = (nb == 16) ? '1 : ((128'd1 << (8 * nb)) - 128'd1);
    v    = {rnd64(op_cnt * 7), rnd64(op_cnt * 7 + 1)};
    dv   = rnd64(op_cnt * 7 + 2);
    nlo  = rnd64(op_cnt * 7 + 3);
    nhi  = rnd64(op_cnt * 7 + 4);
    ud   = (rdst && lk) || (pr && sz < 2) || (pr && rdst);
    al   = !ud && !rdst && ((ofs % nb) != 0);
    mpath = !ud && !al && !rdst;
    dstop = rdst ? {64'd0, dv & m} : ((v >> (8 * ofs)) & bm);
    alo = rnd64(op_cnt * 7 + 5);
    ahi = rnd64(op_cnt * 7 + 6);
    alo = (alo & ~m) | (dstop[63:0] & m);
    if (pr) ahi = (ahi & ~m) | (64'(dstop >> n) & m);
    if (!want_eq) alo = alo ^ (64'd1 << (op_cnt % n));
    accop = pr ? (({64'd0, ahi & m} << n) | {64'd0, alo & m}) : {64'd0, alo & m};
    newop = pr ? (({64'd0, nhi & m} << n) | {64'd0, nlo & m}) : {64'd0, nlo & m};
    eq = accop == dstop;
    // Expected flags from arithmetic on the operands (R9).
    a = accop[63:0]; d = dstop[63:0];
    df = (a - d) & m;
    as_ = 130'(a); if (a[n-1]) as_ = as_ - (130'sd1 <<< n);
    ds_ = 130'(d); if (d[n-1]) ds_ = ds_ - (130'sd1 <<< n);
    r_  = as_ - ds_;
    lim = 130'sd1 <<< (n - 1);
    ef = '0;
    if (ud || al) ef = '0;
    else if (pr) ef[3] = eq;
    else begin
      ef[0] = a < d;
      ef[1] = ~^df[7:0];
      ef[2] = (a & 64'hF) < (d & 64'hF);
      ef[3] = eq;
      ef[4] = df[n-1];
      ef[5] = (r_ >= lim) || (r_ < -lim);
    end
    e_lo = alo; e_hi = ahi; e_dst = dv;
    if (!ud && !al && !eq) begin
      e_lo = (alo & ~m) | (dstop[63:0] & m);
      if (pr) e_hi = (ahi & ~m) | (64'(dstop >> n) & m);
    end
    if (!ud && !al && eq && rdst) e_dst = (dv & ~m) | (nlo & m);
    wbytes  = eq ? newop : dstop;
    exp_wr  = (v & ~(bm << (8 * ofs))) | ((wbytes & bm) << (8 * ofs));
    expline = mpath ? exp_wr : v;
    exp_be  = 16'(((32'd1 << nb) - 32'd1) << ofs);
    tg = pr ? "R6" : (eq ? "R1" : "R2");

    // Preload memory line.
    @(negedge clk);
    pre_en = 1'b1; pre_idx = 2'(line); pre_val = v;
    @(negedge clk);
    pre_en = 1'b0;
    gold[line] = expline;
    // Issue request.
    req_valid = 1'b1; req_addr = 32'h0000_1000 | 32'(line << 4) | 32'(ofs);
    req_size = 2'(sz); req_pair = pr; req_lock = lk; req_reg_dst = rdst;
    req_acc_hi = ahi; req_acc_lo = alo; req_new_hi = nhi; req_new_lo = nlo; req_dst_val = dv;
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 0;
    while (!res_done && cyc < 100) begin
      @(negedge clk);
      cyc++;
    end
    chk(res_done, "R11", "done pulse seen", 128'(res_done), 128'd1);
    chk(res_fault_ud == ud, "R8", "ud fault", 128'(res_fault_ud), 128'(ud));
    chk(res_fault_align == al, "R7", "align fault", 128'(res_fault_align), 128'(al));
    chk(res_success == (!ud && !al && eq), eq ? "R1" : "R2", "success",
        128'(res_success), 128'(!ud && !al && eq));
    chk(res_flags == ef, "R9", "flags", 128'(res_flags), 128'(ef));
    chk(res_acc_lo == e_lo, tg, "acc lo", 128'(res_acc_lo), 128'(e_lo));
    chk(res_acc_hi == e_hi, tg, "acc hi", 128'(res_acc_hi), 128'(e_hi));
    chk(mem[line] == gold[line], mpath ? tg : "R7", "memory line", mem[line], gold[line]);
    if (mpath) begin
      chk(hs_n == 2 && !first_we && last_we, "R3", "read then write count",
          128'(hs_n), 128'd2);
      chk(lock_and == lk && lock_or == lk, lk ? "R4" : "R12", "lock level",
          128'({lock_and, lock_or}), 128'({lk, lk}));
      chk(be_seen == exp_be, "R5", "byte enables", 128'(be_seen), 128'(exp_be));
    end else begin
      chk(hs_n == 0, ud ? "R8" : (al ? "R7" : "R10"), "no memory cycle", 128'(hs_n), 128'd0);
      if (rdst && !ud)
        chk(res_dst_val == e_dst, "R10", "register destination", 128'(res_dst_val), 128'(e_dst));
    end
    @(negedge clk);
    chk(!res_done && req_ready, "R11", "single done then idle",
        128'({res_done, req_ready}), 128'b01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R11", "ready after reset", 128'(req_ready), 128'd1);
    chk(mem_req == 1'b0 && res_done == 1'b0, "R11", "idle after reset",
        128'({mem_req, res_done}), 128'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1 && res_flags == '0, "R11", "reset outputs",
        128'({req_ready, res_flags}), 128'({1'b1, 6'd0}));
    // Memory sweep: sizes, pair mode, every lane offset, lock, match and mismatch.
    for (int sz = 0; sz < 4; sz++)
      for (int pr = 0; pr < 2; pr++)
        for (int ofs = 0; ofs < 16; ofs++)
          for (int lk = 0; lk < 2; lk++)
            for (int e = 0; e < 2; e++)
              run_op(sz, pr[0], lk[0], 1'b0, ofs, e[0]);
    // Register destination sweep.
    for (int sz = 0; sz < 4; sz++)
      for (int pr = 0; pr < 2; pr++)
        for (int lk = 0; lk < 2; lk++)
          for (int e = 0; e < 2; e++)
            run_op(sz, pr[0], lk[0], 1'b1, 0, e[0]);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish act=hung exp=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule